// File: doc/BRIEF.md
# Reset Source Controller with Cause Flags

This block collects every reset request of a small controller system and turns them into two reset outputs. Requests that reach the supply level (power-on or brown-out, wake from standby, wake from shutdown) raise a power reset. The power reset is asserted at once, with no clock edge needed, and is released on the clock. Every other request raises a system reset. These are the external reset pin, the two watchdogs, a software request, a low-power security violation and an option-load request. A power reset also raises a system reset.

A sticky flag vector records which sources caused resets. A system reset leaves the flags alone. A power reset wipes them and leaves only the flag of the power event that caused it. One strobe clears all flags.

The external reset pin is shared and open-drain. Each internal event drives the pin low for a guaranteed minimum time, set from the clock frequency. An optional holder keeps the pin driven until the pin level is sensed low. The incoming pin level goes through a synchroniser and a glitch filter. The filter is blanked while the block drives the pin itself.

Top module: `rst_cause_ctrl`

## Requirements
- R1: `pwr_rst` rises in the same cycle as any of `bor_req`, `stby_exit` or `shdn_exit`, without waiting for a clock edge. It falls after the second rising clock edge at which none of them is high.
- R2: `sys_rst` is high whenever any request, a power reset, a valid pin reset or the pin drive is active. It stays high for exactly two more cycles after the last of these goes away.
- R3: `cause_flags` has these bit positions: 0 power-on/brown-out or shutdown exit, 1 standby exit, 2 external pin, 3 window watchdog, 4 independent watchdog, 5 software, 6 low-power security, 7 option load. A flag is set at the clock edge where its source is sampled high.
- R4: Flags survive system resets. A power event replaces the whole vector with only the flag of that power event (0x01 or 0x02).
- R5: A high `flag_clr` at a clock edge clears all flags. A system source sampled at that same edge still sets its flag.
- R6: In bidirectional mode (`pin_mode` = 0), each internal event (watchdogs, software, security, option load, power reset) drives `pin_drive_low` high for at least PULSE_CYC cycles. PULSE_CYC is 20 µs rounded up at CLK_HZ. A one-cycle event gives exactly PULSE_CYC cycles.
- R7: With `holder_en` high in bidirectional mode, the drive continues after the minimum pulse until the synchronised pin reads low.
- R8: A pin level that is low for at least FILT_CYC synchronised samples becomes a valid reset: it raises `sys_rst` and sets flag 2. Shorter lows are ignored.
- R9: A low level on the pin caused by the block's own drive never sets flag 2.
- R10: `pin_mode` = 1 (input only) accepts pin resets but never drives the pin. `pin_mode` = 2 or 3 (general purpose) neither drives the pin nor takes resets from it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| bor_req | input | 1 | Power-on / brown-out event, active high |
| stby_exit | input | 1 | Wake from standby |
| shdn_exit | input | 1 | Wake from shutdown, treated as brown-out |
| pin_in | input | 1 | Sensed level of the external reset pin |
| wwdg_evt | input | 1 | Window watchdog reset request |
| iwdg_evt | input | 1 | Independent watchdog reset request |
| sw_req | input | 1 | Software reset request |
| lpsec_evt | input | 1 | Low-power security violation |
| optld_req | input | 1 | Option-load reset request |
| flag_clr | input | 1 | Clears all cause flags |
| pin_mode | input | 2 | 0 bidirectional, 1 input only, 2/3 general purpose |
| holder_en | input | 1 | Enables the pin holder |
| pwr_rst | output | 1 | Power reset, active high |
| sys_rst | output | 1 | System reset, active high |
| pin_drive_low | output | 1 | Open-drain pull-down enable for the pin |
| cause_flags | output | 8 | Sticky reset cause flags |

## Verification
Each internal source is applied on its own after a clear. The bench checks that each one sets only its own flag, which separates the bit positions, and that each gives the exact pulse length and two-cycle release. The external pin is tried in three ways: a low held long enough, a glitch one sample too short, and a low while in general-purpose mode. These separate the filter threshold from the mode gating. The holder is exercised with the pin held high past the pulse. This shows the drive waits for the sensed level and that the block's own low never counts as a pin reset. The flag sequence without clears, then standby and shutdown wake-ups, separates keeping the flags across system resets from the selective wipe on power resets.

// File: rtl/rst_cause_pkg.sv
package rst_cause_pkg;

  localparam int NUM_FLAGS = 8;
  localparam int FLG_PWRON = 0;
  localparam int FLG_STBY  = 1;
  localparam int FLG_PIN   = 2;
  localparam int FLG_WWDG  = 3;
  localparam int FLG_IWDG  = 4;
  localparam int FLG_SW    = 5;
  localparam int FLG_LPSEC = 6;
  localparam int FLG_OPTLD = 7;

  typedef enum logic [1:0] {
    PIN_BIDIR  = 2'b00,
    PIN_INPUT  = 2'b01,
    PIN_GPIO   = 2'b10,
    PIN_GPIO_B = 2'b11
  } pin_mode_e;

  typedef enum logic [1:0] {
    PS_IDLE  = 2'b00,
    PS_PULSE = 2'b01,
    PS_HOLD  = 2'b10
  } pulse_state_e;

  // Clock cycles covering a duration in nanoseconds, rounded up.
  function automatic int unsigned ns_to_cycles(input longint unsigned hz,
                                               input longint unsigned ns);
    longint unsigned prod;
    prod = (hz / 64'd1000) * ns;
    return 32'((prod + 64'd999_999) / 64'd1_000_000);
  endfunction

endpackage

// File: rtl/rst_pwr_sync.sv
module rst_pwr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic trig,
  output logic rst
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or posedge trig) begin
    if (trig) chain <= '1;
    else      chain <= {chain[STAGES-2:0], 1'b0};
  end

  assign rst = chain[STAGES-1];

  // Release only after a clock edge with no power trigger.
  assert_release_lag_R1: assert property (@(posedge clk)
    $fell(rst) |-> !$past(trig));

  assert_trig_holds_R1: assert property (@(posedge clk)
    trig |-> rst);

endmodule

// File: rtl/rst_pin_filter.sv
module rst_pin_filter #(
  parameter int unsigned FILT_CYC    = 4,
  parameter int          SYNC_STAGES = 2,
  parameter int unsigned BLANK_CYC   = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_in,
  input  logic enable,
  input  logic self_drive,
  output logic pin_low,
  output logic pin_valid
);
  localparam int CW = $clog2(FILT_CYC + 1);
  localparam int BW = $clog2(BLANK_CYC + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CW-1:0]          low_cnt;
  logic [BW-1:0]          blank_cnt;
  logic                   masked;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) sync_q <= '1;
    else     sync_q <= {sync_q[SYNC_STAGES-2:0], pin_in};
  end

  assign pin_low = !sync_q[SYNC_STAGES-1];

  // Blanking covers the own drive plus the synchroniser delay after it.
  always_ff @(posedge clk or posedge rst) begin
    if (rst)                 blank_cnt <= '0;
    else if (self_drive)     blank_cnt <= BW'(BLANK_CYC);
    else if (blank_cnt != 0) blank_cnt <= blank_cnt - 1'b1;
  end

  assign masked = self_drive || (blank_cnt != 0);

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      low_cnt   <= '0;
      pin_valid <= 1'b0;
    end else if (!enable || masked || !pin_low) begin
      low_cnt   <= '0;
      pin_valid <= 1'b0;
    end else if (low_cnt == CW'(FILT_CYC - 1)) begin
      pin_valid <= 1'b1;
    end else begin
      low_cnt <= low_cnt + 1'b1;
    end
  end

  assert_no_self_R9: assert property (@(posedge clk) disable iff (rst)
    masked |=> !$rose(pin_valid));

  assert_valid_low_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(pin_valid) |-> $past(pin_low));

endmodule

// File: rtl/rst_pin_pulser.sv
module rst_pin_pulser
  import rst_cause_pkg::*;
#(
  parameter int unsigned PULSE_CYC = 320
) (
  input  logic clk,
  input  logic rst,
  input  logic int_req,
  input  logic holder_en,
  input  logic pin_low,
  output logic active
);
  localparam int CW = $clog2(PULSE_CYC + 1);
  localparam logic [CW-1:0] LOAD = CW'(PULSE_CYC - 1);

  pulse_state_e  st;
  logic [CW-1:0] cnt;
  logic          pulse_done;

  assign pulse_done = (st == PS_PULSE) && !int_req && (cnt == '0);

  // A power reset itself counts as an internal event: restart the pulse.
  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      st  <= PS_PULSE;
      cnt <= LOAD;
    end else begin
      case (st)
        PS_IDLE: if (int_req) begin
          st  <= PS_PULSE;
          cnt <= LOAD;
        end
        PS_PULSE: begin
          if (int_req)         cnt <= LOAD;
          else if (pulse_done) st  <= (holder_en && !pin_low) ? PS_HOLD : PS_IDLE;
          else                 cnt <= cnt - 1'b1;
        end
        PS_HOLD: begin
          if (int_req) begin
            st  <= PS_PULSE;
            cnt <= LOAD;
          end else if (pin_low) begin
            st <= PS_IDLE;
          end
        end
        default: st <= PS_IDLE;
      endcase
    end
  end

  assign active = (st != PS_IDLE);

  // Run length of the drive, for the minimum-width check.
  logic [31:0] run_len;
  always_ff @(posedge clk or posedge rst) begin
    if (rst)         run_len <= '0;
    else if (active) run_len <= run_len + 1'b1;
    else             run_len <= '0;
  end

  assert_min_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(active) |-> (run_len >= 32'(PULSE_CYC)));

  assert_event_drives_R6: assert property (@(posedge clk) disable iff (rst)
    int_req |=> active);

  assert_hold_wait_R7: assert property (@(posedge clk) disable iff (rst)
    (st == PS_HOLD && !pin_low && !int_req) |=> active);

endmodule

// File: rtl/rst_cause_flags.sv
module rst_cause_flags #(
  parameter int NF = 8
) (
  input  logic          clk,
  input  logic          pwr_trig,
  input  logic          pwr_hold,
  input  logic [NF-1:0] pwr_set,
  input  logic [NF-1:0] sys_set,
  input  logic          clr,
  output logic [NF-1:0] flags
);
  // Power events overwrite; afterwards set-dominant sticky behaviour.
  always_ff @(posedge clk) begin
    if (pwr_trig)      flags <= pwr_set;
    else if (pwr_hold) flags <= flags;
    else               flags <= (clr ? '0 : flags) | sys_set;
  end

  assert_set_R3: assert property (@(posedge clk) disable iff (pwr_hold || pwr_trig)
    (sys_set != '0) |=> ((flags & $past(sys_set)) == $past(sys_set)));

  assert_keep_R4: assert property (@(posedge clk) disable iff (pwr_hold || pwr_trig)
    !clr |=> ((flags & $past(flags)) == $past(flags)));

  assert_pwr_load_R4: assert property (@(posedge clk)
    pwr_trig |=> (flags == $past(pwr_set)));

  assert_clear_R5: assert property (@(posedge clk) disable iff (pwr_hold || pwr_trig)
    (clr && sys_set == '0) |=> (flags == '0));

endmodule

// File: rtl/rst_cause_ctrl.sv
module rst_cause_ctrl
  import rst_cause_pkg::*;
#(
  parameter int unsigned CLK_HZ      = 16_000_000,
  parameter int unsigned PULSE_NS    = 20_000,
  parameter int unsigned FILT_CYC    = 4,
  parameter int          SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 bor_req,
  input  logic                 stby_exit,
  input  logic                 shdn_exit,
  input  logic                 pin_in,
  input  logic                 wwdg_evt,
  input  logic                 iwdg_evt,
  input  logic                 sw_req,
  input  logic                 lpsec_evt,
  input  logic                 optld_req,
  input  logic                 flag_clr,
  input  logic [1:0]           pin_mode,
  input  logic                 holder_en,
  output logic                 pwr_rst,
  output logic                 sys_rst,
  output logic                 pin_drive_low,
  output logic [NUM_FLAGS-1:0] cause_flags
);
  localparam int unsigned PULSE_CYC = ns_to_cycles(64'(CLK_HZ), 64'(PULSE_NS));
  localparam int unsigned BLANK_CYC = 32'(SYNC_STAGES) + 1;
  localparam int unsigned SYS_TAIL  = 2;
  localparam int          TW        = $clog2(SYS_TAIL + 1);

  pin_mode_e mode;
  logic pwr_trig, int_req, sys_req;
  logic bidir, pin_en;
  logic drive_active, pin_low, pin_valid;
  logic [NUM_FLAGS-1:0] pwr_set, sys_set;
  logic [TW-1:0] sys_tail;

  assign mode   = pin_mode_e'(pin_mode);
  assign bidir  = (mode == PIN_BIDIR);
  assign pin_en = (mode == PIN_BIDIR) || (mode == PIN_INPUT);

  assign pwr_trig = bor_req | stby_exit | shdn_exit;
  assign int_req  = wwdg_evt | iwdg_evt | sw_req | lpsec_evt | optld_req;

  rst_pwr_sync #(.STAGES(SYNC_STAGES)) u_pwr (
    .clk  (clk),
    .trig (pwr_trig),
    .rst  (pwr_rst)
  );

  rst_pin_pulser #(.PULSE_CYC(PULSE_CYC)) u_pulse (
    .clk       (clk),
    .rst       (pwr_rst),
    .int_req   (int_req),
    .holder_en (holder_en & bidir),
    .pin_low   (pin_low),
    .active    (drive_active)
  );

  assign pin_drive_low = drive_active & bidir;

  rst_pin_filter #(
    .FILT_CYC    (FILT_CYC),
    .SYNC_STAGES (SYNC_STAGES),
    .BLANK_CYC   (BLANK_CYC)
  ) u_filt (
    .clk        (clk),
    .rst        (pwr_rst),
    .pin_in     (pin_in),
    .enable     (pin_en),
    .self_drive (pin_drive_low),
    .pin_low    (pin_low),
    .pin_valid  (pin_valid)
  );

  always_comb begin
    pwr_set = '0;
    pwr_set[FLG_PWRON] = bor_req | shdn_exit;
    pwr_set[FLG_STBY]  = stby_exit;
    sys_set = '0;
    sys_set[FLG_PIN]   = pin_valid;
    sys_set[FLG_WWDG]  = wwdg_evt;
    sys_set[FLG_IWDG]  = iwdg_evt;
    sys_set[FLG_SW]    = sw_req;
    sys_set[FLG_LPSEC] = lpsec_evt;
    sys_set[FLG_OPTLD] = optld_req;
  end

  rst_cause_flags #(.NF(NUM_FLAGS)) u_flags (
    .clk      (clk),
    .pwr_trig (pwr_trig),
    .pwr_hold (pwr_rst),
    .pwr_set  (pwr_set),
    .sys_set  (sys_set),
    .clr      (flag_clr),
    .flags    (cause_flags)
  );

  assign sys_req = pwr_rst | bor_req | int_req | pin_valid | pin_drive_low;

  always_ff @(posedge clk) begin
    if (sys_req)            sys_tail <= TW'(SYS_TAIL);
    else if (sys_tail != 0) sys_tail <= sys_tail - 1'b1;
  end

  assign sys_rst = sys_req | (sys_tail != '0);

  assert_pin_reaches_sys_R2: assert property (@(posedge clk)
    pin_valid |-> sys_rst);

  assert_sys_tail_R2: assert property (@(posedge clk) disable iff (pwr_rst)
    $fell(sys_rst) |-> (!$past(sys_req) && !$past(sys_req, 2)));

  assert_gpio_no_pin_R10: assert property (@(posedge clk) disable iff (pwr_rst)
    !pin_en |=> !pin_valid);

endmodule

// File: tb/test_rst_cause_ctrl.sv
module test_rst_cause_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_MHZ    = 16;
  localparam int FILT       = 4;
  localparam int P          = 20 * CLK_MHZ;   // 20 us in cycles
  localparam int WD_LIMIT   = 150_000;
  localparam int NVEC       = 6;
  // {source id, expected flags}; ids 0..4 internal, 5 external pin
  localparam logic [11:0] VEC [NVEC] = '{
    {4'd0, 8'h08}, {4'd1, 8'h10}, {4'd2, 8'h20},
    {4'd3, 8'h40}, {4'd4, 8'h80}, {4'd5, 8'h04}
  };

  logic clk = 1'b0;
  logic bor_req, stby_exit, shdn_exit, pin_in;
  logic wwdg_evt, iwdg_evt, sw_req, lpsec_evt, optld_req, flag_clr, holder_en;
  logic [1:0] pin_mode;
  logic pwr_rst, sys_rst, pin_drive_low;
  logic [7:0] cause_flags;
  logic ext_low, force_hi;
  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // Open-drain pad model
  always_comb pin_in = force_hi ? 1'b1 : ((ext_low || pin_drive_low) ? 1'b0 : 1'b1);

  rst_cause_ctrl #(.CLK_HZ(CLK_MHZ * 1_000_000), .PULSE_NS(20_000), .FILT_CYC(FILT)) i_rst_cause_ctrl (
    .clk(clk), .bor_req(bor_req), .stby_exit(stby_exit), .shdn_exit(shdn_exit),
    .pin_in(pin_in), .wwdg_evt(wwdg_evt), .iwdg_evt(iwdg_evt), .sw_req(sw_req),
    .lpsec_evt(lpsec_evt), .optld_req(optld_req), .flag_clr(flag_clr),
    .pin_mode(pin_mode), .holder_en(holder_en), .pwr_rst(pwr_rst),
    .sys_rst(sys_rst), .pin_drive_low(pin_drive_low), .cause_flags(cause_flags)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_src(input int id, input logic v);
    case (id)
      0: wwdg_evt  = v;
      1: iwdg_evt  = v;
      2: sw_req    = v;
      3: lpsec_evt = v;
      4: optld_req = v;
      default: ext_low = v;
    endcase
  endtask

  task automatic count_drive(output int n);
    n = 0;
    while (pin_drive_low && n < 5000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 3000; i++) begin
      if (!sys_rst && !pin_drive_low) break;
      @(negedge clk);
    end
  endtask

  task automatic clear_flags();
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
  endtask

  task automatic pulse_one(input int id);
    set_src(id, 1'b1);
    @(negedge clk);
    set_src(id, 1'b0);
  endtask

  initial begin
    int n;
    {stby_exit, shdn_exit, wwdg_evt, iwdg_evt, sw_req, lpsec_evt, optld_req} = '0;
    {flag_clr, holder_en, ext_low, force_hi} = '0;
    pin_mode = 2'd0;
    bor_req  = 1'b1;
    repeat (5) @(negedge clk);
    check(pwr_rst == 1'b1, "R1 pwr_rst during bor", int'(pwr_rst), 1);
    check(sys_rst == 1'b1, "R2 sys_rst during bor", int'(sys_rst), 1);
    check(pin_drive_low == 1'b1, "R6 pin driven in power reset", int'(pin_drive_low), 1);
    bor_req = 1'b0;
    @(negedge clk);
    check(pwr_rst == 1'b1, "R1 release lag 1", int'(pwr_rst), 1);
    @(negedge clk);
    check(pwr_rst == 1'b0, "R1 release lag 2", int'(pwr_rst), 0);
    wait_idle();
    check(cause_flags == 8'h01, "R4 flags after power-on", int'(cause_flags), 8'h01);

    // Table walk: every source alone after a clear
    for (int v = 0; v < NVEC; v++) begin
      int id;
      logic [7:0] expf;
      id   = int'(VEC[v][11:8]);
      expf = VEC[v][7:0];
      clear_flags();
      check(cause_flags == 8'h00, "R5 clear", int'(cause_flags), 0);
      if (id < 5) begin
        pulse_one(id);
        count_drive(n);
        check(n == P, "R6 pulse length", n, P);
        check(sys_rst == 1'b1, "R2 tail 0", int'(sys_rst), 1);
        @(negedge clk);
        check(sys_rst == 1'b1, "R2 tail 1", int'(sys_rst), 1);
        @(negedge clk);
        check(sys_rst == 1'b0, "R2 release", int'(sys_rst), 0);
      end else begin
        ext_low = 1'b1;
        repeat (FILT + 4) @(negedge clk);
        check(sys_rst == 1'b1, "R8 pin reset", int'(sys_rst), 1);
        check(pin_drive_low == 1'b0, "R6 no drive on external reset", int'(pin_drive_low), 0);
        ext_low = 1'b0;
        wait_idle();
      end
      check(cause_flags == expf, "R3 R9 flag vector", int'(cause_flags), int'(expf));
    end

    // Sticky across system reset
    pulse_one(2);
    wait_idle();
    check(cause_flags == 8'h24, "R4 kept over system reset", int'(cause_flags), 8'h24);

    // Standby exit: asynchronous assertion, flags replaced
    stby_exit = 1'b1;
    #1;
    check(pwr_rst == 1'b1, "R1 async assert", int'(pwr_rst), 1);
    @(negedge clk);
    stby_exit = 1'b0;
    wait_idle();
    check(cause_flags == 8'h02, "R4 standby wipe", int'(cause_flags), 8'h02);

    pulse_one(0);
    wait_idle();
    shdn_exit = 1'b1;
    @(negedge clk);
    shdn_exit = 1'b0;
    wait_idle();
    check(cause_flags == 8'h01, "R4 shutdown wipe", int'(cause_flags), 8'h01);

    // Clear together with a source: source wins
    flag_clr = 1'b1;
    wwdg_evt = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
    wwdg_evt = 1'b0;
    wait_idle();
    check(cause_flags == 8'h08, "R5 set beats clear", int'(cause_flags), 8'h08);

    // Holder with a slow line
    clear_flags();
    holder_en = 1'b1;
    force_hi  = 1'b1;
    pulse_one(2);
    repeat (P + 10) @(negedge clk);
    check(pin_drive_low == 1'b1, "R7 hold while pin high", int'(pin_drive_low), 1);
    force_hi = 1'b0;
    repeat (3) @(negedge clk);
    check(pin_drive_low == 1'b0, "R7 release after low seen", int'(pin_drive_low), 0);
    wait_idle();
    check(cause_flags == 8'h20, "R9 own low not a pin reset", int'(cause_flags), 8'h20);
    holder_en = 1'b0;

    // Glitch one sample short
    clear_flags();
    ext_low = 1'b1;
    repeat (FILT - 1) @(negedge clk);
    ext_low = 1'b0;
    repeat (6) @(negedge clk);
    check(sys_rst == 1'b0, "R8 glitch no reset", int'(sys_rst), 0);
    check(cause_flags == 8'h00, "R8 glitch no flag", int'(cause_flags), 0);

    // Input-only mode
    pin_mode = 2'd1;
    clear_flags();
    pulse_one(2);
    check(sys_rst == 1'b1, "R10 input-only still resets", int'(sys_rst), 1);
    n = 0;
    for (int i = 0; i < P + 5; i++) begin
      if (pin_drive_low) n++;
      @(negedge clk);
    end
    check(n == 0, "R10 input-only no drive", n, 0);
    check(cause_flags == 8'h20, "R10 input-only flag", int'(cause_flags), 8'h20);
    ext_low = 1'b1;
    repeat (FILT + 4) @(negedge clk);
    ext_low = 1'b0;
    wait_idle();
    check(cause_flags == 8'h24, "R10 input-only pin accepted", int'(cause_flags), 8'h24);

    // General-purpose mode
    pin_mode = 2'd2;
    clear_flags();
    ext_low = 1'b1;
    repeat (3 * FILT) @(negedge clk);
    check(sys_rst == 1'b0, "R10 gpio no reset", int'(sys_rst), 0);
    ext_low = 1'b0;
    repeat (4) @(negedge clk);
    check(cause_flags == 8'h00, "R10 gpio no flag", int'(cause_flags), 0);
    pin_mode = 2'd0;

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    wait (cyc >= WD_LIMIT);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=<%0d", cyc, WD_LIMIT);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule